// File: doc/BRIEF.md
# Transmit Retry and Status Tracker

This block follows one transmit frame through its attempts on the medium and builds the status written back to the frame's descriptor when the frame is finished. The MAC reports what happens during an attempt: the attempt starting, the medium being busy (deferral), a collision, carrier loss, a late collision, a FIFO underflow, a missing end-of-packet marker and a successful completion. The tracker counts retries and decides after each collision whether the MAC should try again or give up. When the frame ends it presents a status byte, a six-bit error field, a reflectometry count and a request to shut down the transmitter, all valid for the single cycle of a done strobe.

A reflectometry counter starts at zero when each attempt begins, advances once per cycle and stops at the first collision of that attempt, saturating at its maximum. The value from the final attempt is reported with the status. A mode input turns off retrying so that the first collision ends the frame with a retry error. A frame-start pulse clears the retry count and the frame's sticky flags.

Top module: `tx_outcome_tracker`

## Requirements
- R1: After reset, `done`, `retry_again`, `tx_disable`, `stat`, `stat2` and `tdr` are all zero.
- R2: When `tx_ok` is seen during an attempt, `done` is high in the next cycle; `stat` bit 3 is set if the frame was retried exactly once and `stat` bit 4 if it was retried two or more times; neither is set for a frame sent at the first attempt.
- R3: A collision during an attempt, while retries are enabled and fewer than RETRY_LIMIT-1 retries have been made, gives a one-cycle `retry_again` pulse in the next cycle, no `done`, and raises the retry count by one; the attempt ends.
- R4: The RETRY_LIMIT-th collision of a frame ends it: `done` with `stat2` bit 0 (retry failure) set and `stat` bit 4 set.
- R5: With `retry_off` high, the first collision ends the frame with `stat2` bit 0 set and `stat` bits 3 and 4 clear.
- R6: `stat` bit 2 is set when `defer_in` was seen in any attempt of the frame, including the final one.
- R7: `stat2` bit 1 reports carrier loss seen in any attempt of the frame (it does not end the attempt); bit 2 late collision, bit 4 underflow, bit 5 missing end-of-packet, each of which ends the attempt at once and takes precedence over a collision or `tx_ok` in the same cycle. `stat2` bit 3 and `stat` bits 0, 1, 5 and 7 are always zero.
- R8: `stat` bit 6 is set exactly when any bit of `stat2` is set.
- R9: `tx_disable` is high on `done` exactly when `stat2` bit 0, 4 or 5 is set; carrier loss and late collision alone do not raise it.
- R10: `tdr` equals the number of cycles from the cycle `attempt_start` is sampled to the first collision (or, without one, the end event) of the final attempt, minus one, saturating at 2^TDR_W-1.
- R11: Event inputs seen while no attempt is in progress have no effect on any output or on the retry count.
- R12: `frame_start` clears the retry count, the deferral and carrier-loss flags and any attempt in progress.
- R13: `stat`, `stat2` and `tdr` are zero in every cycle in which `done` is low, and `done` and `retry_again` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retry_off | input | 1 | Mode: no retries, first collision fails the frame |
| frame_start | input | 1 | New frame; clears count and flags |
| attempt_start | input | 1 | An attempt begins this cycle |
| defer_in | input | 1 | Medium busy, transmission deferred |
| collision | input | 1 | Normal collision |
| carrier_lost | input | 1 | Carrier lost during the attempt |
| late_coll | input | 1 | Late collision |
| underflow | input | 1 | Transmit FIFO underflow |
| no_enp | input | 1 | Buffer chain ended without end-of-packet |
| tx_ok | input | 1 | Attempt completed successfully |
| done | output | 1 | Frame finished; status valid this cycle |
| retry_again | output | 1 | Request for another attempt |
| stat | output | 8 | Status byte |
| stat2 | output | 6 | Error field |
| tdr | output | TDR_W | Reflectometry count |
| tx_disable | output | 1 | Request to disable the transmitter |

## Verification
The bench builds the tracker with RETRY_LIMIT = 4 and TDR_W = 6, so every retry count from zero to the give-up point is swept with each kind of ending, with and without deferral and carrier loss. The six-bit counter saturates at 63, which puts the freeze and saturation of the reflectometry count within a few dozen cycles. Expected status words are assembled arithmetically from the retry count and the flags applied.

// File: rtl/tx_outcome_tracker.sv
module tx_outcome_tracker #(
  parameter int RETRY_LIMIT = 16,
  parameter int TDR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retry_off,
  input  logic             frame_start,
  input  logic             attempt_start,
  input  logic             defer_in,
  input  logic             collision,
  input  logic             carrier_lost,
  input  logic             late_coll,
  input  logic             underflow,
  input  logic             no_enp,
  input  logic             tx_ok,
  output logic             done,
  output logic             retry_again,
  output logic [7:0]       stat,
  output logic [5:0]       stat2,
  output logic [TDR_W-1:0] tdr,
  output logic             tx_disable
);
  localparam int CNT_W = (RETRY_LIMIT > 2) ? $clog2(RETRY_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_LIMIT - 1);
  localparam logic [TDR_W-1:0] TDR_MAX = {TDR_W{1'b1}};

  logic             active, frozen, def_q, lcar_q;
  logic [CNT_W-1:0] rcnt;
  logic [TDR_W-1:0] tdr_cnt;

  wire ev_err  = underflow | no_enp | late_coll;
  wire give_up = active & ~ev_err & collision & (retry_off | rcnt == LAST);
  wire retry   = active & ~ev_err & collision & ~give_up;
  wire finish  = active & (ev_err | give_up | (tx_ok & ~collision));
  wire def_n   = def_q | (active & defer_in);
  wire lcar_n  = lcar_q | (active & carrier_lost);

  wire [5:0] s2_n = {no_enp, underflow, 1'b0, late_coll, lcar_n, give_up};
  wire [7:0] s_n  = {1'b0, |s2_n, 1'b0, rcnt > CNT_W'(1), rcnt == CNT_W'(1),
                     def_n, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      retry_again <= 1'b0;
      stat        <= '0;
      stat2       <= '0;
      tdr         <= '0;
      tx_disable  <= 1'b0;
    end else begin
      done        <= finish;
      retry_again <= retry;
      stat        <= finish ? s_n : '0;
      stat2       <= finish ? s2_n : '0;
      tdr         <= finish ? tdr_cnt : '0;
      tx_disable  <= finish & (underflow | no_enp | give_up);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      active  <= 1'b0;
      frozen  <= 1'b0;
      def_q   <= 1'b0;
      lcar_q  <= 1'b0;
      rcnt    <= '0;
      tdr_cnt <= '0;
    end else if (attempt_start) begin
      active  <= 1'b1;
      frozen  <= 1'b0;
      tdr_cnt <= '0;
    end else if (active) begin
      def_q  <= def_n;
      lcar_q <= lcar_n;
      if (collision | late_coll)
        frozen <= 1'b1;
      else if (!frozen && tdr_cnt != TDR_MAX)
        tdr_cnt <= tdr_cnt + 1'b1;
      if (retry) begin
        active <= 1'b0;
        rcnt   <= rcnt + 1'b1;
      end
      if (finish) begin
        active <= 1'b0;
        rcnt   <= '0;
        def_q  <= 1'b0;
        lcar_q <= 1'b0;
      end
    end
  end
endmodule

module tx_outcome_tracker_chk #(
  parameter int TDR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             retry_again,
  input logic [7:0]       stat,
  input logic [5:0]       stat2,
  input logic [TDR_W-1:0] tdr,
  input logic             tx_disable
);
  // R13
  done_retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && retry_again));
  // R13
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (stat == 8'h00 && stat2 == 6'h00 && tdr == '0));
  // R3
  retry_then_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_again |=> !done);
  // R8
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stat[6] == (|stat2)));
  // R9
  disable_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_disable |-> (done && (stat2[0] || stat2[4] || stat2[5])));
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat2[3] && !stat[0] && !stat[1] && !stat[5] && !stat[7]);
  // R2
  one_or_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[3] && stat[4]));
endmodule

bind tx_outcome_tracker tx_outcome_tracker_chk #(.TDR_W(TDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .retry_again(retry_again),
  .stat(stat), .stat2(stat2), .tdr(tdr), .tx_disable(tx_disable));

// File: tb/tx_outcome_tracker_test.sv
module tx_outcome_tracker_test;
  localparam int LIM = 4;
  localparam int TW  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic retry_off = 0, frame_start = 0, attempt_start = 0, defer_in = 0;
  logic collision = 0, carrier_lost = 0, late_coll = 0, underflow = 0;
  logic no_enp = 0, tx_ok = 0;
  logic done, retry_again, tx_disable;
  logic [7:0] stat;
  logic [5:0] stat2;
  logic [TW-1:0] tdr;

  int checks = 0, errors = 0;
  logic c_done, c_retry, c_dis;
  logic [7:0] c_s;
  logic [5:0] c_s2;
  logic [TW-1:0] c_tdr;

  tx_outcome_tracker #(.RETRY_LIMIT(LIM), .TDR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .retry_off(retry_off), .frame_start(frame_start),
    .attempt_start(attempt_start), .defer_in(defer_in), .collision(collision),
    .carrier_lost(carrier_lost), .late_coll(late_coll), .underflow(underflow),
    .no_enp(no_enp), .tx_ok(tx_ok), .done(done), .retry_again(retry_again),
    .stat(stat), .stat2(stat2), .tdr(tdr), .tx_disable(tx_disable));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic capture();
    c_done = done; c_retry = retry_again; c_dis = tx_disable;
    c_s = stat; c_s2 = stat2; c_tdr = tdr;
  endtask

  task automatic new_frame();
    frame_start = 1; @(negedge clk); frame_start = 0;
  endtask

  // ev: 0 ok, 1 collision, 2 late collision, 3 underflow, 4 no end-of-packet
  task automatic attempt(input int k, input int ev, input bit dfr, input bit lc);
    attempt_start = 1; @(negedge clk); attempt_start = 0;
    repeat (k - 1) @(negedge clk);
    case (ev)
      0: tx_ok = 1;
      1: collision = 1;
      2: late_coll = 1;
      3: underflow = 1;
      default: no_enp = 1;
    endcase
    defer_in = dfr; carrier_lost = lc;
    @(negedge clk);
    tx_ok = 0; collision = 0; late_coll = 0; underflow = 0; no_enp = 0;
    defer_in = 0; carrier_lost = 0;
    capture();
  endtask

  function automatic int retry_bits(input int r);
    return (r == 1 ? 8 : 0) | (r > 1 ? 16 : 0);
  endfunction

  task automatic expect_done(input string req, input int s, input int s2,
                             input int t, input bit dis);
    chk({req, " done"}, c_done, 1);
    chk({req, " stat"}, c_s, s);
    chk({req, " stat2"}, c_s2, s2);
    chk({req, " tdr"}, c_tdr, t);
    chk({req, " tx_disable"}, c_dis, dis);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    capture();
    // R1 reset state
    chk("R1 done", c_done, 0); chk("R1 retry", c_retry, 0);
    chk("R1 stat", c_s, 0); chk("R1 stat2", c_s2, 0);
    chk("R1 tdr", c_tdr, 0); chk("R1 dis", c_dis, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R6 R7 R13: success after r retries, defer and carrier loss
    for (int r = 0; r < LIM; r++)
      for (int d = 0; d < 2; d++)
        for (int l = 0; l < 2; l++) begin
          new_frame();
          for (int i = 0; i < r; i++) begin
            attempt(3 + i, 1, (d == 1) && (i == 0), 1'b0);
            chk("R3 retry_again", c_retry, 1);
            chk("R3 no done", c_done, 0);
            chk("R13 stat idle", {c_s, c_s2}, 0);
          end
          attempt(5, 0, (d == 1) && (r == 0), l[0]);
          expect_done("R2 R6 R7 R8 success",
                      retry_bits(r) | (d * 4) | (l * 64), l * 2, 4, 1'b0);
        end

    // R4 limit reached
    new_frame();
    for (int i = 0; i < LIM - 1; i++) begin
      attempt(2, 1, 1'b0, 1'b0);
      chk("R3 retry below limit", c_retry, 1);
    end
    attempt(7, 1, 1'b0, 1'b0);
    chk("R4 no retry at limit", c_retry, 0);
    expect_done("R4 R9 limit", 8'h50, 6'h01, 6, 1'b1);

    // R5 retries disabled
    retry_off = 1;
    new_frame();
    attempt(2, 1, 1'b0, 1'b0);
    chk("R5 no retry", c_retry, 0);
    expect_done("R5 retry_off", 8'h40, 6'h01, 1, 1'b1);
    retry_off = 0;

    // R7 R9 ending errors after r retries
    for (int ev = 2; ev <= 4; ev++)
      for (int r = 0; r < 3; r++) begin
        new_frame();
        for (int i = 0; i < r; i++) attempt(2, 1, 1'b0, 1'b0);
        attempt(4, ev, 1'b0, 1'b0);
        expect_done("R7 R9 error", 8'h40 | retry_bits(r),
                    ev == 2 ? 6'h04 : (ev == 3 ? 6'h10 : 6'h20), 3, ev != 2);
      end

    // R7 error takes precedence over a collision in the same cycle
    new_frame();
    attempt_start = 1; @(negedge clk); attempt_start = 0;
    underflow = 1; collision = 1; @(negedge clk);
    underflow = 0; collision = 0; capture();
    chk("R7 precedence retry", c_retry, 0);
    expect_done("R7 precedence", 8'h40, 6'h10, 0, 1'b1);

    // R10 reflectometry count, freeze and saturation
    new_frame(); attempt(63, 0, 1'b0, 1'b0);
    chk("R10 tdr 62", c_tdr, 62);
    new_frame(); attempt(64, 0, 1'b0, 1'b0);
    chk("R10 tdr max", c_tdr, 63);
    new_frame(); attempt(70, 0, 1'b0, 1'b0);
    chk("R10 tdr saturate", c_tdr, 63);
    new_frame(); attempt(9, 1, 1'b0, 1'b0); attempt(20, 0, 1'b0, 1'b0);
    chk("R10 tdr last attempt", c_tdr, 19);
    new_frame();
    attempt_start = 1; @(negedge clk); attempt_start = 0;
    repeat (4) @(negedge clk);
    carrier_lost = 1; @(negedge clk); carrier_lost = 0;
    repeat (5) @(negedge clk);
    late_coll = 1; @(negedge clk); late_coll = 0; capture();
    expect_done("R10 R7 late coll freeze", 8'h40, 6'h06, 10, 1'b0);

    // R11 events with no attempt in progress
    new_frame();
    collision = 1; tx_ok = 1; underflow = 1; carrier_lost = 1; defer_in = 1;
    @(negedge clk);
    collision = 0; tx_ok = 0; underflow = 0; carrier_lost = 0; defer_in = 0;
    capture();
    chk("R11 idle done", c_done, 0); chk("R11 idle retry", c_retry, 0);
    chk("R11 idle dis", c_dis, 0);
    attempt(2, 0, 1'b0, 1'b0);
    expect_done("R11 flags untouched", 0, 0, 1, 1'b0);

    // R12 frame_start clears retry count and flags
    new_frame();
    attempt(2, 1, 1'b1, 1'b1);
    attempt(2, 1, 1'b0, 1'b0);
    new_frame();
    attempt(2, 0, 1'b0, 1'b0);
    expect_done("R12 cleared", 0, 0, 1, 1'b0);
    new_frame();
    attempt_start = 1; @(negedge clk); attempt_start = 0;
    new_frame();
    tx_ok = 1; @(negedge clk); tx_ok = 0; capture();
    chk("R12 attempt dropped", c_done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule